// File: doc/BRIEF.md
# Sixteen-Lane Access Coalescer

This unit receives one memory access from a group of sixteen lanes. Each lane carries a byte address and an active bit, and the whole group shares one element size code. The unit decides whether the group can be served by wide transactions. That is possible only when every lane is active, the element size is one of the wide sizes, and lane k reads element k counted up from the lane-0 address. When those rules hold, it issues one or two wide descriptors. When they fail, it issues one narrow descriptor for each active lane.

Descriptors leave on a valid/ready stream. Each descriptor carries an address, a byte count, the lane that produced it, a flag that marks a merged transaction, and a flag that marks the last descriptor of the request. The unit takes one request at a time. It accepts a new request only after the downstream stage has taken the final descriptor of the current one.

Top module: `lanegroup_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1 and `txn_valid` is 0.
- R2: A request merges only when all of these hold:
  - all 16 lanes are active;
  - `req_size` is 2, 3 or 4, where the code means 2^code bytes per element;
  - lane k's address equals the lane-0 address plus k times the element bytes;
  - the lane-0 address is a multiple of the transaction size.

  A misaligned base, a permuted lane or a missing lane each cause the split path.
- R3: A merged request with code 2 gives one 64-byte descriptor at the base address. A merged request with code 3 gives one 128-byte descriptor at the base address. In both cases `txn_merged`=1 and `txn_lane`=0.
- R4: A merged request with code 4 gives two 128-byte descriptors, in order: first at the base address, then at base+128.
- R5: Size codes 0, 1, 5, 6 and 7 never merge, even when the addresses are sequential.
- R6: A request that does not merge gives one descriptor per active lane, in ascending lane order. Each of these descriptors has:
  - the lane's own address;
  - 2^code bytes;
  - `txn_lane` equal to the lane index;
  - `txn_merged`=0.
- R7: Inactive lanes produce no descriptor. A request with no active lane produces none at all, and the unit is ready again on the next cycle.
- R8: `txn_last` is 1 on the final descriptor of a request and 0 on every other descriptor.
- R9: `req_ready` stays 0 from the accepting edge until the final descriptor is taken. It is 1 in the cycle after that handshake.
- R10: While `txn_valid` is 1 and `txn_ready` is 0, the descriptor fields hold steady and `txn_valid` stays 1.
- R11: The address of every merged descriptor is a multiple of its byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 512 | Byte address per lane, lane k in bits [32k+31:32k] |
| req_active | input | 16 | Active bit per lane |
| req_size | input | 3 | Element size code, 2^code bytes |
| txn_valid | output | 1 | Descriptor present |
| txn_ready | input | 1 | Downstream takes the descriptor |
| txn_addr | output | 32 | Descriptor byte address |
| txn_bytes | output | 8 | Descriptor byte count |
| txn_lane | output | 4 | Originating lane (0 when merged) |
| txn_merged | output | 1 | Descriptor is a wide transaction |
| txn_last | output | 1 | Final descriptor of the request |

## Verification
Some properties are checked on every cycle:
- a stalled descriptor holds steady (R10);
- split descriptors climb in lane order (R6);
- a split descriptor belongs to a lane that still has one pending (R7);
- merged addresses are aligned (R11);
- the unit turns ready right after the final handshake (R9).

The merge decision itself can only be shown by the bench's scenarios, because it depends on the whole address pattern: misaligned bases, swapped lanes, a dropped lane and narrow or oversize codes. The same holds for the exact count, addresses and byte counts of the descriptors, which a scoreboard compares with a model of the rules under a stalling ready pattern.

// File: rtl/coal_pkg.sv
package coal_pkg;
   localparam int CODE_W = 3;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MERGE = 2'd1,
      ST_SPLIT = 2'd2
   } seq_state_e;
endpackage

// File: rtl/coal_rule_eval.sv
module coal_rule_eval
   import coal_pkg::*;
#(
   parameter int LANES    = 16,
   parameter int ADDR_W   = 32,
   parameter int MIN_CODE = 2,
   parameter int MAX_CODE = 4,
   parameter int MAX_TXN  = 128,
   parameter int BYTES_W  = 8,
   parameter int BEAT_W   = 2
) (
   input  logic [LANES*ADDR_W-1:0] addr_flat,
   input  logic [LANES-1:0]        active,
   input  logic [CODE_W-1:0]       code,
   output logic                    merge_ok,
   output logic [BYTES_W-1:0]      seg_bytes,
   output logic [BEAT_W-1:0]       beats
);
   localparam int TXN_SH = $clog2(MAX_TXN);

   logic [ADDR_W-1:0] base;
   logic [LANES-1:0]  seq_hit;
   logic [31:0]       span;
   logic [31:0]       seg;
   logic [31:0]       beat_cnt;
   logic              size_ok;
   logic              aligned;

   assign base = addr_flat[ADDR_W-1:0];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [ADDR_W-1:0] want;
      assign want       = base + (ADDR_W'(k) << code);
      assign seq_hit[k] = active[k] && (addr_flat[k*ADDR_W +: ADDR_W] == want);
   end

   always_comb begin
      span     = 32'(LANES) << code;
      seg      = (span > 32'(MAX_TXN)) ? 32'(MAX_TXN) : span;
      beat_cnt = (span > 32'(MAX_TXN)) ? (span >> TXN_SH) : 32'd1;
      size_ok  = (32'(code) >= 32'(MIN_CODE)) && (32'(code) <= 32'(MAX_CODE));
      aligned  = (base & (ADDR_W'(seg) - ADDR_W'(1))) == '0;
   end

   assign merge_ok  = size_ok && (&seq_hit) && aligned;
   assign seg_bytes = BYTES_W'(seg);
   assign beats     = BEAT_W'(beat_cnt);
endmodule

// File: rtl/coal_lane_pick.sv
module coal_lane_pick #(
   parameter int LANES  = 16,
   parameter int LANE_W = 4
) (
   input  logic [LANES-1:0]  mask,
   output logic [LANE_W-1:0] idx,
   output logic              single
);
   logic found;

   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         if (mask[i] && !found) begin
            idx   = LANE_W'(i);
            found = 1'b1;
         end
      end
      single = found && ((mask & (mask - LANES'(1))) == '0);
   end
endmodule

// File: rtl/coal_sequencer.sv
module coal_sequencer
   import coal_pkg::*;
#(
   parameter int LANES   = 16,
   parameter int ADDR_W  = 32,
   parameter int MAX_TXN = 128,
   parameter int BYTES_W = 8,
   parameter int BEAT_W  = 2,
   parameter int LANE_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]        req_active,
   input  logic [CODE_W-1:0]       req_code,
   input  logic                    merge_ok,
   input  logic [BYTES_W-1:0]      seg_bytes,
   input  logic [BEAT_W-1:0]       beats,
   input  logic [LANE_W-1:0]       pick_idx,
   input  logic                    pick_single,
   output logic [LANES-1:0]        rem_mask,
   output logic                    txn_valid,
   input  logic                    txn_ready,
   output logic [ADDR_W-1:0]       txn_addr,
   output logic [BYTES_W-1:0]      txn_bytes,
   output logic [LANE_W-1:0]       txn_lane,
   output logic                    txn_merged,
   output logic                    txn_last
);
   localparam int TXN_SH = $clog2(MAX_TXN);

   seq_state_e                         state_q;
   logic [LANES-1:0][ADDR_W-1:0]       addr_q;
   logic [LANES-1:0]                   rem_q;
   logic [CODE_W-1:0]                  code_q;
   logic [BYTES_W-1:0]                 seg_q;
   logic [BEAT_W-1:0]                  beats_q;
   logic [BEAT_W-1:0]                  beat_q;
   logic                               fire;

   assign fire      = txn_valid && txn_ready;
   assign req_ready = (state_q == ST_IDLE);
   assign rem_mask  = rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         rem_q   <= '0;
         code_q  <= '0;
         seg_q   <= '0;
         beats_q <= '0;
         beat_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  code_q  <= req_code;
                  seg_q   <= seg_bytes;
                  beats_q <= beats;
                  beat_q  <= '0;
                  rem_q   <= req_active;
                  if (merge_ok)        state_q <= ST_MERGE;
                  else if (|req_active) state_q <= ST_SPLIT;
               end
            end
            ST_MERGE: begin
               if (fire) begin
                  if (txn_last) state_q <= ST_IDLE;
                  else          beat_q  <= beat_q + BEAT_W'(1);
               end
            end
            ST_SPLIT: begin
               if (fire) begin
                  rem_q <= rem_q & ~(LANES'(1) << pick_idx);
                  if (pick_single) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      txn_valid  = (state_q != ST_IDLE);
      txn_addr   = '0;
      txn_bytes  = '0;
      txn_lane   = '0;
      txn_merged = 1'b0;
      txn_last   = 1'b0;
      if (state_q == ST_MERGE) begin
         txn_addr   = addr_q[0] + (ADDR_W'(beat_q) << TXN_SH);
         txn_bytes  = seg_q;
         txn_merged = 1'b1;
         txn_last   = (beat_q == beats_q - BEAT_W'(1));
      end else if (state_q == ST_SPLIT) begin
         txn_addr   = addr_q[pick_idx];
         txn_bytes  = BYTES_W'(1) << code_q;
         txn_lane   = pick_idx;
         txn_last   = pick_single;
      end
   end

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr)
         && $stable(txn_lane) && $stable(txn_bytes) && $stable(txn_merged)));

   // R6
   lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !txn_last && !txn_merged) |=> (!txn_merged && txn_lane > $past(txn_lane)));

   // R7
   split_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_merged) |-> rem_q[txn_lane]);

   // R11
   merge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_merged) |-> ((txn_addr & (ADDR_W'(txn_bytes) - ADDR_W'(1))) == '0));

   // R9
   reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && txn_last) |=> req_ready);
endmodule

// File: rtl/lanegroup_coalescer.sv
module lanegroup_coalescer
   import coal_pkg::*;
#(
   parameter int LANES    = 16,
   parameter int ADDR_W   = 32,
   parameter int MIN_CODE = 2,
   parameter int MAX_CODE = 4,
   parameter int MAX_TXN  = 128,
   localparam int LANE_W    = $clog2(LANES),
   localparam int BYTES_W   = $clog2(MAX_TXN) + 1,
   localparam int MAX_SPAN  = LANES << MAX_CODE,
   localparam int MAX_BEATS = (MAX_SPAN > MAX_TXN) ? (MAX_SPAN / MAX_TXN) : 1,
   localparam int BEAT_W    = $clog2(MAX_BEATS) + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]        req_active,
   input  logic [CODE_W-1:0]       req_size,
   output logic                    txn_valid,
   input  logic                    txn_ready,
   output logic [ADDR_W-1:0]       txn_addr,
   output logic [BYTES_W-1:0]      txn_bytes,
   output logic [LANE_W-1:0]       txn_lane,
   output logic                    txn_merged,
   output logic                    txn_last
);
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if ((MAX_TXN & (MAX_TXN - 1)) != 0 || MAX_TXN < 128) begin : g_bad_txn
      $error("MAX_TXN must be a power of two of at least 128");
   end
   if (MIN_CODE > MAX_CODE || MAX_CODE > 7) begin : g_bad_code
      $error("size code range is invalid");
   end

   logic                  merge_ok;
   logic [BYTES_W-1:0]    seg_bytes;
   logic [BEAT_W-1:0]     beats;
   logic [LANE_W-1:0]     pick_idx;
   logic                  pick_single;
   logic [LANES-1:0]      rem_mask;

   coal_rule_eval #(
      .LANES(LANES), .ADDR_W(ADDR_W), .MIN_CODE(MIN_CODE), .MAX_CODE(MAX_CODE),
      .MAX_TXN(MAX_TXN), .BYTES_W(BYTES_W), .BEAT_W(BEAT_W)
   ) u_eval (
      .addr_flat (req_addr),
      .active    (req_active),
      .code      (req_size),
      .merge_ok  (merge_ok),
      .seg_bytes (seg_bytes),
      .beats     (beats)
   );

   coal_lane_pick #(.LANES(LANES), .LANE_W(LANE_W)) u_pick (
      .mask   (rem_mask),
      .idx    (pick_idx),
      .single (pick_single)
   );

   coal_sequencer #(
      .LANES(LANES), .ADDR_W(ADDR_W), .MAX_TXN(MAX_TXN),
      .BYTES_W(BYTES_W), .BEAT_W(BEAT_W), .LANE_W(LANE_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_addr    (req_addr),
      .req_active  (req_active),
      .req_code    (req_size),
      .merge_ok    (merge_ok),
      .seg_bytes   (seg_bytes),
      .beats       (beats),
      .pick_idx    (pick_idx),
      .pick_single (pick_single),
      .rem_mask    (rem_mask),
      .txn_valid   (txn_valid),
      .txn_ready   (txn_ready),
      .txn_addr    (txn_addr),
      .txn_bytes   (txn_bytes),
      .txn_lane    (txn_lane),
      .txn_merged  (txn_merged),
      .txn_last    (txn_last)
   );
endmodule

// File: tb/sim_lanegroup_coalescer.sv
`timescale 1ns/1ps
module sim_lanegroup_coalescer;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [511:0]  req_addr = '0;
   logic [15:0]   req_active = '0;
   logic [2:0]    req_size = '0;
   logic          txn_valid;
   logic          txn_ready = 1'b0;
   logic [31:0]   txn_addr;
   logic [7:0]    txn_bytes;
   logic [3:0]    txn_lane;
   logic          txn_merged;
   logic          txn_last;

   int tests = 0;
   int fails = 0;

   typedef struct {
      logic [31:0] addr;
      int          bytes;
      int          lane;
      bit          merged;
      bit          last;
      string       tag;
   } exp_t;
   exp_t q[$];

   logic [31:0] stim_addr [16];

   always #2 clk = ~clk;

   lanegroup_coalescer u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_active(req_active), .req_size(req_size),
      .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
      .txn_bytes(txn_bytes), .txn_lane(txn_lane), .txn_merged(txn_merged),
      .txn_last(txn_last)
   );

   task automatic fill_seq(input logic [31:0] base, input int stride);
      for (int k = 0; k < 16; k++) stim_addr[k] = base + 32'(k * stride);
   endtask

   // reference model of the merge rules, pushes expected descriptors
   task automatic send(input logic [15:0] act, input int code, input string tag);
      bit   ok;
      int   elem, span, seg, nb, lastk;
      exp_t e;
      elem = 1 << code;
      ok = (code >= 2 && code <= 4);
      for (int k = 0; k < 16; k++)
         if (!act[k] || stim_addr[k] != stim_addr[0] + 32'(k * elem)) ok = 0;
      span = 16 * elem;
      seg  = (span > 128) ? 128 : span;
      if ((stim_addr[0] % 32'(seg)) != 0) ok = 0;
      if (ok) begin
         nb = span / seg;
         for (int b = 0; b < nb; b++) begin
            e.addr = stim_addr[0] + 32'(b * 128); e.bytes = seg; e.lane = 0;
            e.merged = 1; e.last = (b == nb - 1); e.tag = tag;
            q.push_back(e);
         end
      end else begin
         lastk = -1;
         for (int k = 0; k < 16; k++) if (act[k]) lastk = k;
         for (int k = 0; k < 16; k++) if (act[k]) begin
            e.addr = stim_addr[k]; e.bytes = elem; e.lane = k;
            e.merged = 0; e.last = (k == lastk); e.tag = tag;
            q.push_back(e);
         end
      end
      @(negedge clk);
      for (int k = 0; k < 16; k++) req_addr[k*32 +: 32] = stim_addr[k];
      req_active = act;
      req_size   = 3'(code);
      req_valid  = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor / scoreboard
   int          rcnt = 0;
   bit          hold_pend = 0, last_pend = 0;
   logic [31:0] h_addr;
   logic [7:0]  h_bytes;
   logic [3:0]  h_lane;
   always @(negedge clk) begin
      if (rst_n) begin
         rcnt++;
         txn_ready = ((rcnt % 5) != 2) && ((rcnt % 7) != 3);
         #1;
         if (hold_pend) begin
            tests++;
            if (!txn_valid || txn_addr != h_addr || txn_bytes != h_bytes || txn_lane != h_lane) begin
               fails++;
               $display("FAIL R10: held %0b %h/%0d/%0d, expected 1 %h/%0d/%0d",
                        txn_valid, txn_addr, txn_bytes, txn_lane, h_addr, h_bytes, h_lane);
            end
            hold_pend = 0;
         end
         if (last_pend) begin
            tests++;
            if (!req_ready) begin
               fails++;
               $display("FAIL R9: req_ready %0b after final handshake, expected 1", req_ready);
            end
            last_pend = 0;
         end
         if (txn_valid && !txn_ready) begin
            hold_pend = 1; h_addr = txn_addr; h_bytes = txn_bytes; h_lane = txn_lane;
         end
         if (txn_valid && txn_ready) begin
            tests++;
            if (q.size() == 0) begin
               fails++;
               $display("FAIL R7: unexpected descriptor %h lane %0d, expected none", txn_addr, txn_lane);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (txn_addr != e.addr || int'(txn_bytes) != e.bytes ||
                   int'(txn_lane) != e.lane || txn_merged != e.merged) begin
                  fails++;
                  $display("FAIL %s: %h/%0d lane %0d merged %0b, expected %h/%0d lane %0d merged %0b",
                           e.tag, txn_addr, txn_bytes, txn_lane, txn_merged,
                           e.addr, e.bytes, e.lane, e.merged);
               end
               tests++;
               if (txn_last != e.last) begin
                  fails++;
                  $display("FAIL R8: last %0b, expected %0b", txn_last, e.last);
               end
               if (e.merged) begin
                  tests++;
                  if ((txn_addr % 32'(e.bytes)) != 0) begin
                     fails++;
                     $display("FAIL R11: addr %h, expected multiple of %0d", txn_addr, e.bytes);
                  end
               end
               tests++;
               if (req_ready) begin
                  fails++;
                  $display("FAIL R9: req_ready %0b while busy, expected 0", req_ready);
               end
               if (e.last) last_pend = 1;
            end
         end
      end
   end

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1
      tests++;
      if (req_ready !== 1'b1 || txn_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1: ready %0b valid %0b, expected 1 0", req_ready, txn_valid);
      end
      rst_n = 1'b1;

      fill_seq(32'h1000, 4);  send(16'hFFFF, 2, "R3");   // R3 64-byte merge
      fill_seq(32'h2000, 8);  send(16'hFFFF, 3, "R3");   // R3 128-byte merge
      fill_seq(32'h3080, 16); send(16'hFFFF, 4, "R4");   // R4 two beats
      fill_seq(32'h1004, 4);  send(16'hFFFF, 2, "R2");   // R2 misaligned base
      fill_seq(32'h1000, 4);
      stim_addr[1] = 32'h1008; stim_addr[2] = 32'h1004;
      send(16'hFFFF, 2, "R2");                           // R2 permuted lanes
      fill_seq(32'h2040, 8);  send(16'hFFFF, 3, "R2");   // R2 64-aligned only
      fill_seq(32'h4000, 2);  send(16'hFFFF, 1, "R5");   // R5 16-bit elements
      fill_seq(32'h4100, 1);  send(16'hFFFF, 0, "R5");   // R5 byte elements
      fill_seq(32'h8000, 32); send(16'hFFFF, 5, "R5");   // R5 oversize code
      fill_seq(32'h5000, 4);  send(16'hFFFE, 2, "R7");   // R7 lane 0 inactive
      fill_seq(32'h6000, 4);
      stim_addr[15] = 32'h9ABC_0000; stim_addr[0] = 32'h0000_0040;
      send(16'h8001, 3, "R6");                           // R6 sparse mask
      fill_seq(32'h7000, 4);  send(16'h0000, 2, "R7");   // R7 nothing active
      tests++;
      if (!req_ready || txn_valid) begin
         fails++;
         $display("FAIL R7: ready %0b valid %0b after empty request, expected 1 0",
                  req_ready, txn_valid);
      end
      fill_seq(32'h7100, 16); send(16'hFFFF, 4, "R4");   // R4 after empty request

      repeat (200) begin
         @(negedge clk);
         if (q.size() == 0 && !txn_valid) break;
      end
      repeat (4) @(negedge clk);
      tests++;
      if (q.size() != 0 || txn_valid) begin
         fails++;
         $display("FAIL R6: %0d descriptors missing, expected 0", q.size());
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule